// File: doc/BRIEF.md
# Two-Priority Message Dispatch Queue

This block is the receive side of a message-driven processing node. Messages arrive one word per cycle. Each message is placed in one of two on-chip ring buffers, one for each priority level. The block then hands the messages, one at a time, to a handler execution unit.

A message is a header word followed by a body:

- The header's low bits give the body length.
- The first body word is the address of the handler code.
- The remaining body words are the handler's arguments.

While a handler runs, it can read any body word by its offset from the start of the body. When the handler finishes, it pulses `suspend`. That pulse releases the message's ring storage and starts dispatch of the next pending message.

High-priority messages always win at the point of selection. A running handler is never interrupted. The storage of a message stays claimed until the handler suspends, so the handler can read its arguments at any time. An arrival that cannot fit in its ring is held off with `in_ready` low until space is freed.

Top module: `prio_msg_queue`

## Requirements
- R1: After reset, `act_valid` and `rd_err` are 0, both rings are empty, and a header of body length 1 sees `in_ready` high.
- R2: The header word's bits [LEN_W-1:0] give the body length L, from 1 to 2^LEN_W-1; the other header bits are ignored. A message uses L+1 ring words. A header is accepted only when its priority's ring has at least L+1 free words; otherwise `in_ready` is low. A header with L=0 is never accepted. Body words after an accepted header are always accepted. Each ring's space is independent of the other ring.
- R3: Within one priority, messages are dispatched in arrival order.
- R4: When no handler is active and both rings hold complete messages, the high-priority message (`in_prio`=1 on its header) is dispatched first.
- R5: An active handler stays active, with unchanged `act_ip` and `act_prio`, until `suspend`. This holds even when higher-priority messages arrive.
- R6: On dispatch, `act_ip` is body word 0, `act_len` is L, and `act_prio` is the message's priority. With the block idle and empty, `act_valid` rises on the 4th rising edge after the edge that accepts the message's last word.
- R7: While a handler is active, `rd_en` with `rd_off`=k and k<L gives body word k on `rd_data`, with `rd_err`=0, in the cycle after the request.
- R8: `rd_en` with k>=L, or with no active handler, gives `rd_data`=0 and `rd_err`=1 in the cycle after the request.
- R9: A message's ring words are freed only by `suspend`, and are free from the edge that takes the suspend. A header held off by a full ring is accepted in the next cycle.
- R10: A `suspend` pulse while no handler is active is ignored: queued messages and their order are kept.
- R11: A message is not dispatched until its last body word has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arrival word present |
| in_ready | output | 1 | Arrival word accepted at this edge if valid |
| in_word | input | W | Header or body word |
| in_prio | input | 1 | Priority of the message, sampled with its header (1 = high) |
| act_valid | output | 1 | A handler is active |
| act_prio | output | 1 | Priority of the active message |
| act_ip | output | W | Handler code address (body word 0) |
| act_len | output | LEN_W | Body length of the active message |
| suspend | input | 1 | Handler completion pulse |
| rd_en | input | 1 | Body word read request |
| rd_off | input | LEN_W | Body word offset |
| rd_data | output | W | Read result, one cycle after the request |
| rd_err | output | 1 | Out-of-range or idle read, one cycle after the request |

## Verification
Dispatch is due on the fourth edge after the last arrival word. The bench counts negedges from the return of its send task and checks `act_valid` low on the third and high on the fourth. Read results are due one cycle after `rd_en`, so each read task samples at the next falling edge. After `suspend`, released space is visible straight away, so `in_ready` is checked at the negedge that follows the suspend edge. Each following dispatch is awaited with a bounded poll before its code address is compared.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  typedef enum logic [2:0] {
    DS_IDLE = 3'd0,
    DS_HDR  = 3'd1,
    DS_IP   = 3'd2,
    DS_LOAD = 3'd3,
    DS_RUN  = 3'd4
  } disp_state_t;

  localparam int unsigned RING_LO = 0;
  localparam int unsigned RING_HI = 1;
  localparam int unsigned NRINGS  = 2;
endpackage

// File: rtl/msgq_ring.sv
module msgq_ring #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       wr_commit,
  input  logic                       pop,
  input  logic [LEN_W:0]             pop_words,
  input  logic                       rd_en,
  input  logic [LEN_W:0]             rd_off,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH):0]     msg_cnt,
  output logic [$clog2(DEPTH):0]     free_words
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr, used;
  logic [AW-1:0] raddr;
  logic [W-1:0]  rd_q;

  assign used       = wr_ptr - rd_ptr;
  assign free_words = (AW+1)'(DEPTH) - used;
  assign raddr      = rd_ptr[AW-1:0] + AW'(rd_off);
  assign rd_data    = rd_q;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    if (rd_en) rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      msg_cnt <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (pop)   rd_ptr <= rd_ptr + (AW+1)'(pop_words);
      case ({wr_commit, pop})
        2'b10:   msg_cnt <= msg_cnt + 1'b1;
        2'b01:   msg_cnt <= msg_cnt - 1'b1;
        default: msg_cnt <= msg_cnt;
      endcase
    end
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (used < (AW+1)'(DEPTH)));
  p_pop_has_msg_r9: assert property (@(posedge clk) disable iff (rst)
    pop |-> (msg_cnt != '0));
  p_commit_with_write_r11: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> wr_en);
endmodule

// File: rtl/msgq_ingress.sv
module msgq_ingress #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LEN_W-1:0]       hdr_len,
  input  logic                   in_prio,
  input  logic [$clog2(DEPTH):0] free_hi,
  input  logic [$clog2(DEPTH):0] free_lo,
  output logic                   in_ready,
  output logic [1:0]             wr_en,
  output logic [1:0]             wr_commit
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic             busy, tgt, acc, cur_prio, fit, last;
  logic [LEN_W-1:0] remain;
  logic [AW:0]      need, free_sel;

  assign need     = (AW+1)'(hdr_len) + 1'b1;
  assign free_sel = in_prio ? free_hi : free_lo;
  assign fit      = (hdr_len != '0) && (free_sel >= need);
  assign in_ready = busy | fit;
  assign acc      = in_valid & in_ready;
  assign cur_prio = busy ? tgt : in_prio;
  assign last     = busy && (remain == LEN_W'(1));

  always_comb begin
    wr_en[1]     = acc & cur_prio;
    wr_en[0]     = acc & ~cur_prio;
    wr_commit[1] = wr_en[1] & last;
    wr_commit[0] = wr_en[0] & last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      tgt    <= 1'b0;
      remain <= '0;
    end else if (acc) begin
      if (!busy) begin
        busy   <= 1'b1;
        remain <= hdr_len;
        tgt    <= in_prio;
      end else begin
        remain <= remain - 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  p_prio_held_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> (busy && $stable(tgt)));
endmodule

// File: rtl/msgq_dispatch.sv
module msgq_dispatch
  import msgq_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(DEPTH):0] cnt_hi,
  input  logic [$clog2(DEPTH):0] cnt_lo,
  input  logic [W-1:0]           rdata_hi,
  input  logic [W-1:0]           rdata_lo,
  output logic [1:0]             ring_ren,
  output logic [LEN_W:0]         ring_roff,
  output logic [1:0]             pop,
  output logic [LEN_W:0]         pop_words,
  input  logic                   suspend,
  input  logic                   rd_en,
  input  logic [LEN_W-1:0]       rd_off,
  output logic                   act_valid,
  output logic                   act_prio,
  output logic [W-1:0]           act_ip,
  output logic [LEN_W-1:0]       act_len,
  output logic [W-1:0]           rd_data,
  output logic                   rd_err
);
  disp_state_t      st;
  logic             sel, act_q, hit_q, err_q, rd_ok;
  logic [LEN_W-1:0] len_q;
  logic [W-1:0]     ip_q, rsel;

  assign rsel  = sel ? rdata_hi : rdata_lo;
  assign rd_ok = (st == DS_RUN) && (rd_off < len_q);

  always_comb begin
    ring_ren  = 2'b00;
    ring_roff = '0;
    case (st)
      DS_HDR: begin ring_ren[sel] = 1'b1; ring_roff = '0; end
      DS_IP:  begin ring_ren[sel] = 1'b1; ring_roff = (LEN_W+1)'(1); end
      DS_RUN: if (rd_en && rd_ok) begin
        ring_ren[sel] = 1'b1;
        ring_roff     = {1'b0, rd_off} + 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    pop          = 2'b00;
    pop[sel]     = (st == DS_RUN) && suspend;
    pop_words    = {1'b0, len_q} + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= DS_IDLE;
      sel   <= 1'b0;
      act_q <= 1'b0;
      len_q <= '0;
      ip_q  <= '0;
      hit_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      hit_q <= rd_en && rd_ok;
      err_q <= rd_en && !rd_ok;
      case (st)
        DS_IDLE: begin
          if (cnt_hi != '0) begin
            sel <= 1'b1;
            st  <= DS_HDR;
          end else if (cnt_lo != '0) begin
            sel <= 1'b0;
            st  <= DS_HDR;
          end
        end
        DS_HDR:  st <= DS_IP;
        DS_IP: begin
          len_q <= rsel[LEN_W-1:0];
          st    <= DS_LOAD;
        end
        DS_LOAD: begin
          ip_q  <= rsel;
          act_q <= 1'b1;
          st    <= DS_RUN;
        end
        DS_RUN: begin
          if (suspend) begin
            act_q <= 1'b0;
            st    <= DS_IDLE;
          end
        end
        default: st <= DS_IDLE;
      endcase
    end
  end

  assign act_valid = act_q;
  assign act_prio  = sel;
  assign act_ip    = ip_q;
  assign act_len   = len_q;
  assign rd_data   = hit_q ? rsel : '0;
  assign rd_err    = err_q;

  p_hi_first_r4: assert property (@(posedge clk) disable iff (rst)
    (st == DS_IDLE && cnt_hi != '0) |=> (sel == 1'b1));
  p_no_preempt_r5: assert property (@(posedge clk) disable iff (rst)
    (act_q && !suspend) |=> (act_q && $stable(ip_q) && $stable(sel)));
  p_idle_suspend_r10: assert property (@(posedge clk) disable iff (rst)
    !act_q |-> (pop == 2'b00));
  p_err_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_data == '0));
  p_one_ring_read_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ring_ren));
endmodule

// File: rtl/prio_msg_queue.sv
module prio_msg_queue
  import msgq_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_word,
  input  logic             in_prio,
  output logic             act_valid,
  output logic             act_prio,
  output logic [W-1:0]     act_ip,
  output logic [LEN_W-1:0] act_len,
  input  logic             suspend,
  input  logic             rd_en,
  input  logic [LEN_W-1:0] rd_off,
  output logic [W-1:0]     rd_data,
  output logic             rd_err
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [1:0]       wr_en, wr_commit, ring_ren, pop;
  logic [LEN_W:0]   ring_roff, pop_words;
  logic [AW:0]      msg_cnt [NRINGS];
  logic [AW:0]      free_w  [NRINGS];
  logic [W-1:0]     rdata   [NRINGS];

  msgq_ingress #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ingress (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .hdr_len   (in_word[LEN_W-1:0]),
    .in_prio   (in_prio),
    .free_hi   (free_w[RING_HI]),
    .free_lo   (free_w[RING_LO]),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_commit (wr_commit)
  );

  for (genvar g = 0; g < NRINGS; g++) begin : g_ring
    msgq_ring #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_ring (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (wr_en[g]),
      .wr_data    (in_word),
      .wr_commit  (wr_commit[g]),
      .pop        (pop[g]),
      .pop_words  (pop_words),
      .rd_en      (ring_ren[g]),
      .rd_off     (ring_roff),
      .rd_data    (rdata[g]),
      .msg_cnt    (msg_cnt[g]),
      .free_words (free_w[g])
    );
  end

  msgq_dispatch #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dispatch (
    .clk       (clk),
    .rst       (rst),
    .cnt_hi    (msg_cnt[RING_HI]),
    .cnt_lo    (msg_cnt[RING_LO]),
    .rdata_hi  (rdata[RING_HI]),
    .rdata_lo  (rdata[RING_LO]),
    .ring_ren  (ring_ren),
    .ring_roff (ring_roff),
    .pop       (pop),
    .pop_words (pop_words),
    .suspend   (suspend),
    .rd_en     (rd_en),
    .rd_off    (rd_off),
    .act_valid (act_valid),
    .act_prio  (act_prio),
    .act_ip    (act_ip),
    .act_len   (act_len),
    .rd_data   (rd_data),
    .rd_err    (rd_err)
  );
endmodule

// File: tb/prio_msg_queue_bench.sv
module prio_msg_queue_bench;
  localparam int W = 32;
  localparam int DEPTH = 32;
  localparam int LEN_W = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_prio = 1'b0, suspend = 1'b0, rd_en = 1'b0;
  logic [W-1:0] in_word = '0;
  logic [LEN_W-1:0] rd_off = '0;
  logic in_ready, act_valid, act_prio, rd_err;
  logic [W-1:0] act_ip, rd_data;
  logic [LEN_W-1:0] act_len;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_msg_queue #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_prio_msg_queue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_prio(in_prio), .act_valid(act_valid),
    .act_prio(act_prio), .act_ip(act_ip), .act_len(act_len),
    .suspend(suspend), .rd_en(rd_en), .rd_off(rd_off),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // tasks start and end at a falling edge
  task automatic push_word(input logic [W-1:0] w, input logic p);
    in_valid = 1'b1; in_word = w; in_prio = p;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_msg(input logic p, input logic [W-1:0] ip, input int len);
    push_word(32'hA500_0000 | W'(len), p);
    for (int k = 0; k < len; k++) push_word(ip + W'(k), p);
  endtask

  task automatic pulse_suspend();
    suspend = 1'b1;
    @(negedge clk);
    suspend = 1'b0;
  endtask

  task automatic wait_act();
    for (int i = 0; i < 20; i++) begin
      if (act_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input int off, output logic [W-1:0] d, output logic e);
    rd_en = 1'b1; rd_off = LEN_W'(off);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; e = rd_err;
  endtask

  task automatic t_reset();
    in_word = 32'h1;
    #1;
    chk("R1 act_valid", W'(act_valid), 0);
    chk("R1 rd_err", W'(rd_err), 0);
    chk("R1 in_ready", W'(in_ready), 1);
  endtask

  task automatic t_basic();
    logic [W-1:0] d; logic e;
    send_msg(1'b0, 32'h100, 3);
    repeat (3) @(negedge clk);
    chk("R6 not yet at 3rd edge", W'(act_valid), 0);
    @(negedge clk);
    chk("R6 valid at 4th edge", W'(act_valid), 1);
    chk("R6 act_ip", act_ip, 32'h100);
    chk("R6 act_len", W'(act_len), 3);
    chk("R6 act_prio", W'(act_prio), 0);
    for (int k = 0; k < 3; k++) begin
      do_read(k, d, e);
      chk("R7 data", d, 32'h100 + W'(k));
      chk("R7 err", W'(e), 0);
    end
    do_read(3, d, e);
    chk("R8 off=len data", d, 0);
    chk("R8 off=len err", W'(e), 1);
    do_read(15, d, e);
    chk("R8 off=15 err", W'(e), 1);
    pulse_suspend();
    chk("R9 released", W'(act_valid), 0);
  endtask

  task automatic t_partial_idle();
    logic [W-1:0] d; logic e;
    pulse_suspend();
    chk("R10 idle suspend", W'(act_valid), 0);
    do_read(0, d, e);
    chk("R8 idle read err", W'(e), 1);
    chk("R8 idle read data", d, 0);
    push_word(32'h3, 1'b1);
    push_word(32'h900, 1'b1);
    repeat (10) @(negedge clk);
    chk("R11 partial not dispatched", W'(act_valid), 0);
    pulse_suspend();
    push_word(32'h901, 1'b1);
    push_word(32'h902, 1'b1);
    wait_act();
    chk("R11/R10 dispatched", act_ip, 32'h900);
    chk("R11 hi prio", W'(act_prio), 1);
    pulse_suspend();
  endtask

  task automatic t_order();
    send_msg(1'b0, 32'h1000, 2);
    wait_act();
    chk("R3 first A", act_ip, 32'h1000);
    send_msg(1'b0, 32'h2000, 1);
    send_msg(1'b1, 32'h3000, 3);
    send_msg(1'b1, 32'h4000, 1);
    repeat (6) @(negedge clk);
    chk("R5 still active", W'(act_valid), 1);
    chk("R5 ip held", act_ip, 32'h1000);
    chk("R5 prio held", W'(act_prio), 0);
    pulse_suspend();
    wait_act();
    chk("R4 hi first", act_ip, 32'h3000);
    pulse_suspend();
    wait_act();
    chk("R3 hi order", act_ip, 32'h4000);
    pulse_suspend();
    wait_act();
    chk("R3 lo last", act_ip, 32'h2000);
    pulse_suspend();
  endtask

  task automatic t_full();
    send_msg(1'b1, 32'h5000, 15);
    wait_act();
    chk("R6 full first", act_ip, 32'h5000);
    send_msg(1'b1, 32'h6000, 15);
    in_word = 32'h1; in_prio = 1'b1;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2 full ring holds off", W'(in_ready), 0);
      @(negedge clk);
    end
    in_prio = 1'b0; #1;
    chk("R2 other ring free", W'(in_ready), 1);
    in_word = 32'h0; #1;
    chk("R2 zero length refused", W'(in_ready), 0);
    in_word = 32'h1; in_prio = 1'b1; #1;
    chk("R9 not freed before suspend", W'(in_ready), 0);
    pulse_suspend();
    #1;
    chk("R9 freed on suspend", W'(in_ready), 1);
    send_msg(1'b1, 32'h7000, 1);
    wait_act();
    chk("R3 second full msg", act_ip, 32'h6000);
    pulse_suspend();
    wait_act();
    chk("R9 late msg", act_ip, 32'h7000);
    pulse_suspend();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_partial_idle();
    t_order();
    t_full();
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule